// File: doc/BRIEF.md
# SSB receive demodulator datapath

This block turns a stream of paired in-phase and quadrature converter codes into one audio level for a pulse-width DAC. Each accepted strobe removes the mid-scale offset from both codes and pushes the signed samples into two raw delay lines. Every fourth strobe the lines are low-pass filtered and the results are pushed into a decimated-rate stage.

At that stage the quadrature branch goes through a sparse antisymmetric 90-degree phase-shift FIR. The in-phase branch is delayed by the same group delay. The difference of the two is scaled down, re-biased to mid-range and clipped to the DAC span. A one-cycle valid pulse marks each new level. The level is held between updates.

The block sits between a sampling converter front end and a PWM audio generator, and runs at the system clock. The strobe may be asserted on any cycle, back to back included.

Top module: `ssb_rx_demod`

## Requirements
- R1: Each 12-bit input code becomes a signed sample equal to code minus 2048, so code 0 maps to -2048 and code 4095 maps to +2047.
- R2: Every strobe shifts each channel's signed sample into a 15-entry raw line, newest at index 14, whether or not the strobe is a decimation strobe.
- R3: A 2-bit counter cleared by reset advances on each strobe. The filter stage runs only on the strobe that wraps it to zero, that is the 4th, 8th, 12th strobe after reset.
- R4: The low-pass output is the sum over the 15 raw taps of tap[k]·c[k], arithmetically shifted right by 8. The coefficients c are 3,3,5,7,9,10,11,11,11,10,9,7,5,3,3.
- R5: On each filter run the filtered I and Q values enter decimated-rate lines, with the newest at index 14 and a 15-entry span.
- R6: The phase-shifted Q value is ((q0−q14)·315 + (q2−q12)·440 + (q4−q10)·734 + (q6−q8)·2202), arithmetically shifted right by 12, where qk are the filtered Q line entries.
- R7: The pre-clip level is (i7 − qh)/8 with the division truncating toward zero, plus 125, where i7 is the filtered I entry at index 7.
- R8: The audio level is clipped to 0..250 inclusive, and both limits are reachable.
- R9: Take a decimation strobe sampled at rising edge T. At edge T+2 the block raises valid_o for exactly one cycle and loads the new audio level. At all other edges audio_o holds its value.
- R10: Reset clears all delay lines and the decimation counter. It drives valid_o low and audio_o to 125.
- R11: The results do not depend on the spacing of strobes, which may arrive on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Sample strobe; I and Q codes accepted when high |
| i_code_i | input | 12 | In-phase converter code, offset binary |
| q_code_i | input | 12 | Quadrature converter code, offset binary |
| audio_o | output | 8 | Clipped audio level, 0..250 |
| valid_o | output | 1 | One-cycle pulse on each audio update |

## Verification
With strobes on every cycle, a new strobe shifts the raw lines on the same edge where the filter stage reads them for the preceding decimation strobe. On that edge the filtered lines also shift while the output register loads the previous result. The bench drives long runs of cycle-by-cycle strobes, then random strobe gaps of zero to three idle cycles, so both overlaps occur. On every cycle it compares valid_o and audio_o with an arithmetic model of R1–R8, using the R9 latency. A reset in mid-stream and slow full-scale square waves on Q confirm that state clears and that both clip limits are reached.

// File: rtl/ssb_rx_pkg.sv
package ssb_rx_pkg;
  localparam int TAPS   = 15;
  localparam int NPAIR  = (TAPS + 1) / 4;  // antisymmetric pairs at even offsets
  localparam int MID_IX = TAPS / 2;

  // symmetric low-pass, 8-bit scale
  function automatic int lpf_coef(input int idx);
    int m;
    m = (idx > MID_IX) ? (TAPS - 1 - idx) : idx;
    case (m)
      0, 1:    return 3;
      2:       return 5;
      3:       return 7;
      4:       return 9;
      5:       return 10;
      default: return 11;
    endcase
  endfunction

  // phase-shift pair weights, 12-bit scale
  function automatic int hilb_coef(input int k);
    case (k)
      0:       return 315;
      1:       return 440;
      2:       return 734;
      default: return 2202;
    endcase
  endfunction
endpackage

// File: rtl/ssb_tap_line.sv
module ssb_tap_line #(
  parameter int W     = 13,
  parameter int DEPTH = 15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic signed [W-1:0] din_i,
  output logic signed [W-1:0] taps_o [DEPTH]
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      taps_o[g] <= '0;
      else if (shift_i) taps_o[g] <= (g == DEPTH - 1) ? din_i : taps_o[(g == DEPTH - 1) ? g : g + 1];
    end
  end

  p_newest_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> taps_o[DEPTH-1] == $past(din_i));
  p_shift_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> taps_o[0] == $past(taps_o[1]));
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(taps_o[0]) && $stable(taps_o[DEPTH-1]));
endmodule

// File: rtl/ssb_lpf_fir.sv
module ssb_lpf_fir
  import ssb_rx_pkg::*;
#(
  parameter int IN_W  = 13,
  parameter int OUT_W = 16,
  parameter int ACC_W = 32,
  parameter int SHIFT = 8
) (
  input  logic signed [IN_W-1:0]  taps_i [TAPS],
  output logic signed [OUT_W-1:0] y_o
);
  logic signed [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++)
      acc = acc + ACC_W'(taps_i[k]) * ACC_W'(lpf_coef(k));
    y_o = OUT_W'(acc >>> SHIFT);
  end
endmodule

// File: rtl/ssb_hilbert_q.sv
module ssb_hilbert_q
  import ssb_rx_pkg::*;
#(
  parameter int W     = 16,
  parameter int ACC_W = 32,
  parameter int SHIFT = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic signed [W-1:0] din_i,
  output logic signed [W-1:0] y_o
);
  logic signed [W-1:0]     line_q [TAPS];
  logic signed [ACC_W-1:0] acc;

  for (genvar g = 0; g < TAPS; g++) begin : g_q
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      line_q[g] <= '0;
      else if (shift_i) line_q[g] <= (g == TAPS - 1) ? din_i : line_q[(g == TAPS - 1) ? g : g + 1];
    end
  end

  // only even offsets carry weight; odd entries are pure delay
  always_comb begin
    acc = '0;
    for (int k = 0; k < NPAIR; k++)
      acc = acc + (ACC_W'(line_q[2*k]) - ACC_W'(line_q[TAPS-1-2*k])) * ACC_W'(hilb_coef(k));
    y_o = W'(acc >>> SHIFT);
  end

  p_q_newest_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> line_q[TAPS-1] == $past(din_i));
  p_q_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(y_o));
endmodule

// File: rtl/ssb_delay.sv
module ssb_delay #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic signed [W-1:0] din_i,
  output logic signed [W-1:0] dout_o
);
  logic signed [W-1:0] stg_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_d
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stg_q[g] <= '0;
      else if (shift_i) stg_q[g] <= (g == DEPTH - 1) ? din_i : stg_q[(g == DEPTH - 1) ? g : g + 1];
    end
  end

  assign dout_o = stg_q[0];

  p_delay_move_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> dout_o == $past(stg_q[1]));
endmodule

// File: rtl/ssb_demod_out.sv
module ssb_demod_out #(
  parameter int W       = 16,
  parameter int ACC_W   = 32,
  parameter int OUT_W   = 8,
  parameter int DAC_MAX = 250,
  parameter int DIV_SH  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] i_mid_i,
  input  logic signed [W-1:0] qh_i,
  output logic [OUT_W-1:0]    audio_o,
  output logic                valid_o
);
  localparam int BIAS    = DAC_MAX / 2;
  localparam int DIVISOR = 1 << DIV_SH;

  logic signed [ACC_W-1:0] diff, lvl;
  logic [OUT_W-1:0]        clip;

  always_comb begin
    diff = ACC_W'(i_mid_i) - ACC_W'(qh_i);
    lvl  = diff / ACC_W'(DIVISOR) + ACC_W'(BIAS);  // signed divide truncates toward zero
    if (lvl < 0)                    clip = '0;
    else if (lvl > ACC_W'(DAC_MAX)) clip = OUT_W'(DAC_MAX);
    else                            clip = OUT_W'(lvl);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      audio_o <= OUT_W'(BIAS);
      valid_o <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) audio_o <= clip;
    end
  end

  p_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    audio_o <= OUT_W'(DAC_MAX));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(audio_o) && !valid_o);
  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> valid_o);
endmodule

// File: rtl/ssb_rx_demod.sv
module ssb_rx_demod
  import ssb_rx_pkg::*;
#(
  parameter int ADC_W     = 12,
  parameter int FILT_W    = 16,
  parameter int ACC_W     = 32,
  parameter int DEC_RATIO = 4,
  parameter int OUT_W     = 8,
  parameter int DAC_MAX   = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [ADC_W-1:0] i_code_i,
  input  logic [ADC_W-1:0] q_code_i,
  output logic [OUT_W-1:0] audio_o,
  output logic             valid_o
);
  localparam int SMP_W = ADC_W + 1;
  localparam int CNT_W = $clog2(DEC_RATIO);
  localparam int MID   = 1 << (ADC_W - 1);
  localparam int DLY_D = MID_IX + 1;  // I group delay match

  logic signed [SMP_W-1:0]  i_smp, q_smp;
  logic signed [SMP_W-1:0]  i_raw [TAPS];
  logic signed [SMP_W-1:0]  q_raw [TAPS];
  logic signed [FILT_W-1:0] i_flt, q_flt, i_mid, q_hil;
  logic [CNT_W-1:0]         dec_cnt;
  logic                     fire_q, hil_en_q;

  assign i_smp = $signed({1'b0, i_code_i}) - SMP_W'(MID);
  assign q_smp = $signed({1'b0, q_code_i}) - SMP_W'(MID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_cnt  <= '0;
      fire_q   <= 1'b0;
      hil_en_q <= 1'b0;
    end else begin
      if (strobe_i) dec_cnt <= dec_cnt + 1'b1;
      fire_q   <= strobe_i && (dec_cnt == CNT_W'(DEC_RATIO - 1));
      hil_en_q <= fire_q;
    end
  end

  ssb_tap_line #(.W(SMP_W), .DEPTH(TAPS)) u_i_raw (
    .clk_i, .rst_ni, .shift_i(strobe_i), .din_i(i_smp), .taps_o(i_raw));
  ssb_tap_line #(.W(SMP_W), .DEPTH(TAPS)) u_q_raw (
    .clk_i, .rst_ni, .shift_i(strobe_i), .din_i(q_smp), .taps_o(q_raw));

  ssb_lpf_fir #(.IN_W(SMP_W), .OUT_W(FILT_W), .ACC_W(ACC_W)) u_i_lpf (
    .taps_i(i_raw), .y_o(i_flt));
  ssb_lpf_fir #(.IN_W(SMP_W), .OUT_W(FILT_W), .ACC_W(ACC_W)) u_q_lpf (
    .taps_i(q_raw), .y_o(q_flt));

  ssb_hilbert_q #(.W(FILT_W), .ACC_W(ACC_W)) u_hil (
    .clk_i, .rst_ni, .shift_i(fire_q), .din_i(q_flt), .y_o(q_hil));
  ssb_delay #(.W(FILT_W), .DEPTH(DLY_D)) u_i_dly (
    .clk_i, .rst_ni, .shift_i(fire_q), .din_i(i_flt), .dout_o(i_mid));

  ssb_demod_out #(.W(FILT_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .DAC_MAX(DAC_MAX)) u_out (
    .clk_i, .rst_ni, .en_i(hil_en_q), .i_mid_i(i_mid), .qh_i(q_hil),
    .audio_o, .valid_o);

  p_dec_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> dec_cnt == '0);
  p_fire_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> $past(strobe_i));
  p_fire_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q);
  p_valid_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> ##1 valid_o);
endmodule

// File: tb/tb_ssb_rx_demod.sv
module tb_ssb_rx_demod;
  localparam int CLK_HALF = 4;  // 8-unit period, 125 MHz at 1 ns units
  localparam int WD_CYC   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic [11:0] i_code_i = '0, q_code_i = '0;
  logic [7:0]  audio_o;
  logic        valid_o;

  int n_chk = 0, n_err = 0;
  int mri[15], mrq[15], mfi[15], mfq[15];
  int mcnt = 0;
  bit ev[3];
  int ea[3];
  int last_a = 125;
  int saw_hi = 0, saw_lo = 0, n_fire = 0, n_valid = 0;
  bit done = 0;
  int unsigned lcg = 32'h1234_5678;

  ssb_rx_demod dut (.clk_i, .rst_ni, .strobe_i, .i_code_i, .q_code_i, .audio_o, .valid_o);

  always #CLK_HALF clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lpf_c(input int k);
    int t[15] = '{3, 3, 5, 7, 9, 10, 11, 11, 11, 10, 9, 7, 5, 3, 3};
    return t[k];
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 15; k++) begin
      mri[k] = 0; mrq[k] = 0; mfi[k] = 0; mfq[k] = 0;
    end
    mcnt = 0;
    for (int k = 0; k < 3; k++) begin ev[k] = 0; ea[k] = 0; end
  endtask

  task automatic model_push(input logic [11:0] iv, input logic [11:0] qv,
                            output bit fire, output int lvl);
    int si, sq, ai, aq, qh;
    si = int'(iv) - 2048;  // R1
    sq = int'(qv) - 2048;
    for (int k = 0; k < 14; k++) begin mri[k] = mri[k+1]; mrq[k] = mrq[k+1]; end
    mri[14] = si; mrq[14] = sq;
    mcnt = (mcnt + 1) % 4;  // R3
    fire = (mcnt == 0);
    lvl = 0;
    if (fire) begin
      ai = 0; aq = 0;
      for (int k = 0; k < 15; k++) begin ai += mri[k] * lpf_c(k); aq += mrq[k] * lpf_c(k); end
      for (int k = 0; k < 14; k++) begin mfi[k] = mfi[k+1]; mfq[k] = mfq[k+1]; end
      mfi[14] = ai >>> 8; mfq[14] = aq >>> 8;
      qh = ((mfq[0] - mfq[14]) * 315 + (mfq[2] - mfq[12]) * 440 +
            (mfq[4] - mfq[10]) * 734 + (mfq[6] - mfq[8]) * 2202) >>> 12;
      lvl = (mfi[7] - qh) / 8 + 125;
      if (lvl < 0) lvl = 0;
      if (lvl > 250) lvl = 250;
    end
  endtask

  task automatic check_out(input string tag);
    if (ev[2]) begin
      chk(valid_o === 1'b1, "R9 valid pulse", int'(valid_o), 1);
      chk(int'(audio_o) == ea[2], tag, int'(audio_o), ea[2]);
      last_a = ea[2];
      if (ea[2] == 250) saw_hi++;
      if (ea[2] == 0) saw_lo++;
    end else begin
      chk(valid_o === 1'b0, "R9 no pulse", int'(valid_o), 0);
      chk(int'(audio_o) == last_a, "R9 hold", int'(audio_o), last_a);
    end
    if (valid_o === 1'b1) n_valid++;
  endtask

  task automatic cyc(input bit stb, input logic [11:0] iv, input logic [11:0] qv, input string tag);
    bit f;
    int l;
    @(negedge clk_i);
    check_out(tag);
    f = 0; l = 0;
    if (stb) model_push(iv, qv, f, l);
    if (f) n_fire++;
    ev[2] = ev[1]; ea[2] = ea[1]; ev[1] = ev[0]; ea[1] = ea[0]; ev[0] = f; ea[0] = l;
    strobe_i = stb; i_code_i = iv; q_code_i = qv;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; strobe_i = 1'b0;
    model_clear();
    last_a = 125;
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R10 reset valid", int'(valid_o), 0);
    chk(int'(audio_o) == 125, "R10 reset level", int'(audio_o), 125);
    rst_ni = 1'b1;
  endtask

  function automatic int unsigned nxt();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg >> 8;
  endfunction

  initial begin
    model_clear();
    do_reset();
    // R3: first three strobes give no pulse, fourth does
    for (int s = 0; s < 3; s++) cyc(1, 12'hfff, 12'h000, "R3 early");
    for (int s = 0; s < 4; s++) cyc(0, 12'h000, 12'h000, "R3 idle");
    chk(n_valid == 0, "R3 no early output", n_valid, 0);
    cyc(1, 12'hfff, 12'h000, "R3 fourth");
    for (int s = 0; s < 4; s++) cyc(0, 12'h000, 12'h000, "R3 idle");
    chk(n_valid == 1, "R3 fourth strobe output", n_valid, 1);
    // R1 R4 R7 R11: constant sweep, back-to-back strobes
    for (int v = 0; v < 4096; v += 128)
      for (int s = 0; s < 40; s++)
        cyc(1, 12'(v), 12'(4095 - v), "R1 R4 R7 sweep");
    cyc(1, 12'hfff, 12'hfff, "R1 top code");
    // R6 R8: slow full-scale Q square, I at both extremes
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 512; s++)
        cyc(1, (p == 0) ? 12'hfff : 12'h000, ((s / 128) % 2 == 1) ? 12'hfff : 12'h000, "R6 R8 square");
    // R10: mid-run reset clears lines and counter
    for (int s = 0; s < 6; s++) cyc(1, 12'h123, 12'hedc, "R10 pre");
    do_reset();
    for (int s = 0; s < 40; s++) cyc(1, 12'(100 * s), 12'(4000 - 90 * s), "R10 post");
    // R2 R5 R11: random data, random strobe gaps
    for (int s = 0; s < 3000; s++) begin
      int unsigned r;
      r = nxt();
      cyc(1, 12'(r), 12'(r >> 12), "R2 R5 random");
      for (int g = 0; g < int'(nxt() % 4); g++) cyc(0, 12'(nxt()), 12'(nxt()), "R2 idle");
    end
    for (int s = 0; s < 6; s++) cyc(0, 12'h000, 12'h000, "drain");
    chk(saw_hi > 0, "R8 upper clip reached", saw_hi, 1);
    chk(saw_lo > 0, "R8 lower clip reached", saw_lo, 1);
    chk(n_valid == n_fire, "R3 pulse count", n_valid, n_fire);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYC, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule